// File: doc/BRIEF.md
# Ring Burst Interrupt Controller

This block turns a ring-active level from the line interface into a host interrupt. The level arrives asynchronously. It passes through a flop synchronizer, and then the block finds the rising edge (start of burst) and the falling edge (end of burst). Each accepted event sets one status flag. The host clears the flag by writing 0 to it. Writing 1 to the flag does nothing.

A control register holds three settings:
- A mode bit that selects one or two interrupts per burst.
- A polarity bit that sets the active level of the interrupt pin.
- A select bit that decides what drives the shared output pin: the interrupt, or a monitor signal that is passed straight through.

In two-interrupt mode, an end-of-burst interrupt appears only if the host has already cleared the start-of-burst interrupt when the burst ends. A burst that starts while the flag is still set leaves the flag set and queues nothing.

Top module: `ring_irq_ctrl`

## Requirements
- R1: After reset, the control readback is 8'h03 and the status flag is clear.
- R2: Control register fields:
  - Bit 7 is the pin select.
  - Bit 6 is the polarity.
  - Bit 2 is the mode.
  - Bits 1:0 are plain stored bits.
  - Bits 5:3 always read zero, so writing 8'hFF reads back 8'hC7.
- R3: A start of burst sets the flag at the third rising clock edge after the ring input changes. The flag is still clear after the second edge.
- R4: With mode = 0, the end of a burst never sets the flag.
- R5: With mode = 1, the end of a burst sets the flag if the flag is clear at that moment, that is, if the start interrupt was already serviced.
- R6: With mode = 1, if the start interrupt was not serviced before the burst ended, the flag stays set and no second interrupt is held back for later.
- R7: A status write with data 0 clears the flag at the next clock edge. A status write with data 1 leaves the flag unchanged.
- R8: If a clearing write and a flag-setting event fall on the same clock edge, the flag ends up set.
- R9: A burst that starts while the flag is set keeps it set. A single clear then leaves it clear, because nothing was queued.
- R10: With select = 0, the pin equals mon_i in the same cycle.
- R11: With select = 1, the pin equals the inverted flag when polarity = 0, and equals the flag when polarity = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_active_i | input | 1 | Asynchronous ring-active level |
| mon_i | input | 1 | Monitor signal routed to the pin when select = 0 |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Status write data (0 clears the flag) |
| irq_flag_o | output | 1 | Ring interrupt status flag |
| irq_pin_o | output | 1 | Shared output pin |

## Verification
Results fall due at different times:
- A change on ring_active_i reaches the flag at the third rising edge: two synchronizer flops, then the flag register.
- Status and control writes take effect at the next edge.
- The pin follows its inputs combinationally.

The bench drives every input just after a falling edge and samples just after a later falling edge. For the latency requirement it samples after exactly the second and third edges. For the other ring checks it waits four edges before sampling. The set-versus-clear race is hit by placing the write strobe in the one cycle where the synchronized edge is present.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
  localparam int CTL_W   = 8;
  localparam int POS_SEL = 7;
  localparam int POS_POL = 6;
  localparam int POS_TWO = 2;
  localparam int AUX_W   = 2;

  typedef struct packed {
    logic             pin_sel;
    logic             pol_hi;
    logic             two_irq;
    logic [AUX_W-1:0] aux;
  } ctl_t;

  localparam ctl_t CTL_RST = '{pin_sel: 1'b0, pol_hi: 1'b0, two_irq: 1'b0, aux: 2'b11};

  function automatic ctl_t ctl_decode(input logic [CTL_W-1:0] d);
    ctl_t c;
    c.pin_sel = d[POS_SEL];
    c.pol_hi  = d[POS_POL];
    c.two_irq = d[POS_TWO];
    c.aux     = d[AUX_W-1:0];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_encode(input ctl_t c);
    logic [CTL_W-1:0] d;
    d = '0;
    d[POS_SEL]     = c.pin_sel;
    d[POS_POL]     = c.pol_hi;
    d[POS_TWO]     = c.two_irq;
    d[AUX_W-1:0]   = c.aux;
    return d;
  endfunction

  function automatic logic end_event_fires(input logic two_irq, input logic flag_now);
    return two_irq & ~flag_now;
  endfunction

  function automatic logic pin_level(input logic sel, input logic pol_hi,
                                     input logic flag, input logic mon);
    logic irq_lvl;
    irq_lvl = pol_hi ? flag : ~flag;
    return sel ? irq_lvl : mon;
  endfunction
endpackage

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

  initial begin
    a_r3_min_stages: assert (STAGES >= 2);
  end
endmodule

// File: rtl/ring_edge.sv
module ring_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  // R3: a rise is followed by a settled-high level on the next cycle
  a_r3_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ring_ctl_reg.sv
module ring_ctl_reg
  import ring_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o,
  output logic [CTL_W-1:0] rdata_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_q <= CTL_RST;
    else if (we_i) ctl_q <= ctl_decode(wdata_i);
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = ctl_encode(ctl_q);

  // R2: a write lands on the following cycle with reserved bits dropped
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (rdata_o == ($past(wdata_i) & 8'hC7)));
  // R2: without a write the register holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/ring_irq_flag.sv
module ring_irq_flag
  import ring_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic fall_i,
  input  logic two_irq_i,
  input  logic clr_i,
  output logic set_evt_o,
  output logic flag_o
);
  logic flag_q;
  logic end_ok;

  assign end_ok    = fall_i & end_event_fires(two_irq_i, flag_q);
  assign set_evt_o = rise_i | end_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (set_evt_o) flag_q <= 1'b1;
    else if (clr_i)     flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R3 / R9 / R8: any start edge leaves the flag set, even against a clear
  a_r3_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> flag_o);
  // R5: serviced start in two-interrupt mode gives an end interrupt
  a_r5_end_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && two_irq_i && !flag_o) |=> flag_o);
  // R4: one-interrupt mode never raises at the end
  a_r4_no_end_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !two_irq_i && !flag_o) |=> !flag_o);
  // R7: clear without a competing event empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rise_i && !fall_i) |=> !flag_o);
  // R7: flag only rises through an accepted event
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !rise_i && !fall_i) |=> !flag_o);
endmodule

// File: rtl/ring_irq_ctrl.sv
module ring_irq_ctrl
  import ring_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_active_i,
  input  logic             mon_i,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             sts_we,
  input  logic             sts_wdata,
  output logic             irq_flag_o,
  output logic             irq_pin_o
);
  ctl_t ctl;
  logic ring_sync_lvl;
  logic ring_rise;
  logic ring_fall;
  logic host_clr;
  logic flag_set_evt;

  assign host_clr = sts_we & ~sts_wdata;

  ring_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ring_active_i), .sync_o(ring_sync_lvl)
  );

  ring_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(ring_sync_lvl),
    .rise_o(ring_rise), .fall_o(ring_fall)
  );

  ring_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .we_i(ctl_we), .wdata_i(ctl_wdata),
    .ctl_o(ctl), .rdata_o(ctl_rdata)
  );

  ring_irq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .rise_i(ring_rise), .fall_i(ring_fall),
    .two_irq_i(ctl.two_irq), .clr_i(host_clr),
    .set_evt_o(flag_set_evt), .flag_o(irq_flag_o)
  );

  assign irq_pin_o = pin_level(ctl.pin_sel, ctl.pol_hi, irq_flag_o, mon_i);

  // R10: monitor passthrough when the interrupt is not selected
  a_r10_mon_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[POS_SEL] |-> (irq_pin_o == mon_i));
  // R11: selected pin is asserted exactly when the flag is set
  a_r11_pin_active: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[POS_SEL] |-> ((irq_pin_o == ctl_rdata[POS_POL]) == irq_flag_o));
  // R7: a write of 1 with no event leaves the flag unchanged
  a_r7_write_one: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && sts_wdata && !flag_set_evt) |=> $stable(irq_flag_o));
endmodule

// File: tb/ring_irq_ctrl_test.sv
`timescale 1ns/1ps
module ring_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ring = 0, mon = 0, ctl_we = 0, sts_we = 0, sts_wdata = 0;
  logic [7:0] ctl_wdata = 0;
  logic [7:0] ctl_rdata;
  logic flag, pin;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ring_active_i(ring), .mon_i(mon),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .irq_flag_o(flag), .irq_pin_o(pin)
  );

  function automatic logic want_pin(logic sel, logic pol, logic f, logic m);
    if (!sel) return m;
    return (f == 1'b1) ? pol : ~pol;
  endfunction

  function automatic logic want_end(logic two, logic serviced);
    if (!serviced) return 1'b1;
    return two;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(logic [7:0] d);
    ctl_wdata = d; ctl_we = 1; cyc(1); ctl_we = 0;
  endtask

  task automatic wr_sts(logic b);
    sts_wdata = b; sts_we = 1; cyc(1); sts_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic sel, pol, two, srv;
    process::self().srandom(32'd7011);
    #(CLK_PERIOD*3);
    @(negedge clk); rst_n = 1; cyc(1);
    chk("R1 ctl", ctl_rdata, 8'h03);
    chk("R1 flag", {7'd0, flag}, 8'h00);
    mon = 1; #1; chk("R10 mon hi", {7'd0, pin}, 8'h01);
    mon = 0; #1; chk("R10 mon lo", {7'd0, pin}, 8'h00);

    wr_ctl(8'hFF);
    chk("R2 reserved", ctl_rdata, 8'hC7);
    wr_ctl(8'h00);
    chk("R2 clear", ctl_rdata, 8'h00);

    // R3 latency: clear after two edges, set after three
    ring = 1; cyc(2);
    chk("R3 edge2", {7'd0, flag}, 8'h00);
    cyc(1);
    chk("R3 edge3", {7'd0, flag}, 8'h01);
    ring = 0; cyc(4);
    chk("R4 mode0 end", {7'd0, flag}, 8'h01);
    wr_sts(1);
    chk("R7 write1 keeps", {7'd0, flag}, 8'h01);
    wr_sts(0);
    chk("R7 write0 clears", {7'd0, flag}, 8'h00);
    wr_sts(1);
    chk("R7 write1 on clear", {7'd0, flag}, 8'h00);

    // R8: clear strobe lands on the same edge as the start event
    ring = 1; cyc(2);
    sts_wdata = 0; sts_we = 1; cyc(1); sts_we = 0;
    chk("R8 set wins", {7'd0, flag}, 8'h01);
    ring = 0; cyc(4); wr_sts(0);

    // R6 / R9: mode 1, unserviced start, then a new burst while set
    wr_ctl(8'h04);
    ring = 1; cyc(4); ring = 0; cyc(4);
    chk("R6 unserviced end", {7'd0, flag}, 8'h01);
    ring = 1; cyc(4);
    chk("R9 start while set", {7'd0, flag}, 8'h01);
    wr_sts(0); cyc(4);
    chk("R9 nothing queued", {7'd0, flag}, 8'h00);
    ring = 0; cyc(4);
    chk("R5 end after service", {7'd0, flag}, 8'h01);
    wr_sts(0);

    // Random bursts across modes, polarity and pin select
    for (int i = 0; i < 60; i++) begin
      sel = 1'($urandom); pol = 1'($urandom); two = 1'($urandom);
      mon = 1'($urandom);
      wr_ctl({sel, pol, 3'b000, two, 2'($urandom)});
      chk("R11 idle pin", {7'd0, pin}, {7'd0, want_pin(sel, pol, 1'b0, mon)});
      ring = 1; cyc(3 + int'($urandom % 3));
      chk("R3 start", {7'd0, flag}, 8'h01);
      chk(sel ? "R11 pin" : "R10 pin", {7'd0, pin}, {7'd0, want_pin(sel, pol, 1'b1, mon)});
      srv = 1'($urandom);
      if (srv) begin
        wr_sts(0);
        chk("R7 service", {7'd0, flag}, 8'h00);
      end
      cyc(int'($urandom % 4));
      ring = 0; cyc(4);
      chk(two ? (srv ? "R5 end" : "R6 end") : "R4 end",
          {7'd0, flag}, {7'd0, want_end(two, srv)});
      chk(sel ? "R11 pin end" : "R10 pin end", {7'd0, pin},
          {7'd0, want_pin(sel, pol, want_end(two, srv), mon)});
      wr_sts(0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule